// File: doc/BRIEF.md
# Asynchronous SRAM strobe controller

This block sits between a clocked host and an asynchronous static RAM of 512K eight-bit words. The host offers one read or write request at a time over a valid/ready handshake. The controller then plays out the active-low chip-select, write-strobe and output-enable sequence that the memory needs. Each phase of that sequence lasts a whole number of clock cycles. That count comes from nanosecond parameters, rounded up at the configured clock period.

The memory's data bus is bidirectional. The controller does not instantiate a pad. It gives out the byte to drive, a driver enable and the byte sampled from the bus, and the tri-state buffer is built outside the block. Reads end with a one-cycle response pulse that carries the captured byte.

The control is one state machine with six states:
- **IDLE**: ready is high and every strobe is inactive.
- **WR_SETUP**: chip select is low, and the state waits for the bus turnaround.
- **WR_PULSE**: the write strobe is low.
- **WR_HOLD**: the strobes are high and the drivers are still on.
- **RD_ACCESS**: chip select and output enable are low.
- **RD_DONE**: the strobes are high and the response is valid.

The transitions are:
- **accept-write** takes IDLE to WR_SETUP.
- **accept-read** takes IDLE to RD_ACCESS.
- **turnaround-met** takes WR_SETUP to WR_PULSE.
- **pulse-done** takes WR_PULSE to WR_HOLD.
- **hold-done** takes WR_HOLD to IDLE.
- **access-done** takes RD_ACCESS to RD_DONE.
- **respond** takes RD_DONE to IDLE.

Top module: `sram_strobe_ctrl`

## Requirements
- R1: After reset and whenever no request is in progress:
  - `req_ready` is 1.
  - `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1.
  - `mem_dq_oe` is 0.
  - `rsp_rdata` is 0 until the first read completes.
- R2: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 in the next cycle. Address, data and direction are taken only at acceptance, so later changes on the request inputs have no effect on the transaction.
- R3: A write (`req_write`=1) runs in this order:
  - One setup cycle with `mem_ce_n`=0, `mem_we_n`=1 and drivers off.
  - WP cycles with `mem_ce_n`=0, `mem_we_n`=0, drivers on and `mem_dq_out` equal to the accepted byte.
  - DH cycles with both strobes at 1 and drivers still on with the same byte.
- R4: `mem_oe_n` stays 1 for the whole of a write, and `mem_we_n` is never 0 unless `mem_ce_n` is 0.
- R5: A read (`req_write`=0) holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1, with drivers off, for AA cycles. The byte on `mem_dq_in` is captured at the edge that ends the last of those cycles.
- R6: In the cycle after a read's access window:
  - The strobes are all 1.
  - `rsp_valid` is 1 for exactly that one cycle.
  - `rsp_rdata` carries the captured byte and holds it until the next read completes.
  - A write never raises `rsp_valid`.
- R7: `req_ready` returns to 1 exactly one cycle after the last cycle in which any strobe was low.
- R8: `mem_dq_oe` is 1 only while `mem_oe_n` is 1 and has been 1 for at least TURN full cycles.
- R9: `mem_addr` equals the accepted address and stays constant for as long as `mem_ce_n` is 0 within a transaction.
- R10: Each phase count is the nanosecond figure divided by `CLK_PERIOD_NS`, rounded up, with a minimum of 1. The counts are WP from `T_WP_NS`, AA from `T_AA_NS`, TURN from `T_OEHZ_NS` and DH from `T_DH_NS`. The defaults give WP=2, AA=2, TURN=1 and DH=1 at a 10 ns clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host offers a request |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (8) | Byte to write |
| rsp_valid | output | 1 | One-cycle read completion pulse |
| rsp_rdata | output | DATA_W (8) | Last byte read |
| mem_addr | output | ADDR_W (19) | Memory address lines |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W (8) | Byte for the bus drivers |
| mem_dq_oe | output | 1 | Bus driver enable, active high |
| mem_dq_in | input | DATA_W (8) | Byte sampled from the bus |

## Verification
The bench's memory model returns inverted data until the access window's final cycle. A controller that captured one edge early would therefore return the complement of the stored byte.

The memory model stores a byte only on the rising edge of the write strobe, taking the value then on the driver output. Dropping the driver before that edge, or writing a stale byte, shows up on read-back.

The request inputs are scrambled right after acceptance. A design that resampled them would move the address mid-transaction or write the wrong byte.

Requests are held pending while the controller is busy. Each one is expected to start only after a visible ready cycle, so an early acceptance or a missing recovery cycle shifts every strobe the reference model expects.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_HOLD,
        ST_RD_ACCESS,
        ST_RD_DONE
    } ctrl_state_e;

    // Whole cycles covering a nanosecond figure, never fewer than one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int WP_CYC   = 2,
    parameter int AA_CYC   = 2,
    parameter int DH_CYC   = 1,
    parameter int TURN_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic rsp_valid,
    output logic mem_ce_n,
    output logic mem_we_n,
    output logic mem_oe_n,
    output logic mem_dq_oe
);

    localparam int CMAX_A = (WP_CYC > AA_CYC) ? WP_CYC : AA_CYC;
    localparam int CMAX   = (CMAX_A > DH_CYC) ? CMAX_A : DH_CYC;
    localparam int CNT_W  = $clog2(CMAX + 1);
    localparam int QW     = $clog2(TURN_CYC + 2);

    ctrl_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [QW-1:0]    quiet_q;
    logic             turn_ok;

    assign turn_ok = (quiet_q >= QW'(TURN_CYC));

    // Next state and phase counter.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;              // accept-write
                        cnt_d   = '0;
                    end else begin
                        state_d = ST_RD_ACCESS;             // accept-read
                        cnt_d   = CNT_W'(AA_CYC - 1);
                    end
                end
            end
            ST_WR_SETUP: begin
                if (turn_ok) begin
                    state_d = ST_WR_PULSE;                  // turnaround-met
                    cnt_d   = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WR_PULSE: begin
                if (cnt_q == '0) begin
                    state_d = ST_WR_HOLD;                   // pulse-done
                    cnt_d   = CNT_W'(DH_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_WR_HOLD: begin
                if (cnt_q == '0) state_d = ST_IDLE;          // hold-done
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_RD_ACCESS: begin
                if (cnt_q == '0) state_d = ST_RD_DONE;       // access-done
                else             cnt_d   = cnt_q - 1'b1;
            end
            ST_RD_DONE: state_d = ST_IDLE;                  // respond
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Cycles elapsed with output enable high, saturating at the turnaround.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        quiet_q <= QW'(TURN_CYC);
        else if (!mem_oe_n)                quiet_q <= '0;
        else if (quiet_q < QW'(TURN_CYC))  quiet_q <= quiet_q + 1'b1;
    end

    // Outputs decoded from the current state.
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        mem_ce_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_WR_SETUP:  mem_ce_n  = 1'b0;
            ST_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD:   mem_dq_oe = 1'b1;
            ST_RD_ACCESS: begin
                mem_ce_n = 1'b0;
                mem_oe_n = 1'b0;
            end
            ST_RD_DONE:   rsp_valid = 1'b1;
            default:      req_ready = 1'b0;
        endcase
    end

    assign accept  = (state_q == ST_IDLE) && req_valid;
    assign capture = (state_q == ST_RD_ACCESS) && (cnt_q == '0);

endmodule

// File: rtl/sram_ctrl_xfer.sv
module sram_ctrl_xfer #(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= mem_dq_in;
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sram_strobe_ctrl.sv
module sram_strobe_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_WP_NS       = 15,
    parameter int T_AA_NS       = 12,
    parameter int T_OEHZ_NS     = 6,
    parameter int T_DH_NS       = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);

    localparam int WP_CYC   = ns_to_cyc(T_WP_NS,   CLK_PERIOD_NS);
    localparam int AA_CYC   = ns_to_cyc(T_AA_NS,   CLK_PERIOD_NS);
    localparam int TURN_CYC = ns_to_cyc(T_OEHZ_NS, CLK_PERIOD_NS);
    localparam int DH_CYC   = ns_to_cyc(T_DH_NS,   CLK_PERIOD_NS);

    logic accept;
    logic capture;

    sram_ctrl_seq #(
        .WP_CYC   (WP_CYC),
        .AA_CYC   (AA_CYC),
        .DH_CYC   (DH_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .rsp_valid (rsp_valid),
        .mem_ce_n  (mem_ce_n),
        .mem_we_n  (mem_we_n),
        .mem_oe_n  (mem_oe_n),
        .mem_dq_oe (mem_dq_oe)
    );

    sram_ctrl_xfer #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rsp_rdata  (rsp_rdata)
    );

endmodule

// File: rtl/sram_strobe_ctrl_chk.sv
module sram_strobe_ctrl_chk #(
    parameter int ADDR_W   = 19,
    parameter int TURN_CYC = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic              mem_ce_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe,
    input logic [ADDR_W-1:0] mem_addr
);

    logic armed;
    int   quiet;

    // Independent count of cycles with output enable high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
            quiet <= TURN_CYC;
        end else begin
            armed <= 1'b1;
            if (!mem_oe_n)             quiet <= 0;
            else if (quiet < TURN_CYC) quiet <= quiet + 1;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_hold_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(mem_we_n)) |-> mem_dq_oe);

    assert_no_oe_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n));

    assert_rsp_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rsp_valid) |-> $past(!mem_oe_n));

    assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_ready_after_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $rose(req_ready)) |-> ($past(mem_ce_n) && $past(mem_oe_n)));

    assert_drive_turnaround_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && quiet >= TURN_CYC));

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

bind sram_strobe_ctrl sram_strobe_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_ce_n  (mem_ce_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe),
    .mem_addr  (mem_addr)
);

// File: tb/sram_strobe_ctrl_tb.sv
module sram_strobe_ctrl_tb;

    localparam int AW     = 19;
    localparam int DW     = 8;
    localparam int PERIOD = 10;
    // R10: phase counts worked out here from the nanosecond defaults.
    localparam int WP = (15 + PERIOD - 1) / PERIOD;
    localparam int AA = (12 + PERIOD - 1) / PERIOD;
    localparam int DH = (1 + PERIOD - 1) / PERIOD;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = '0;

    sram_strobe_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic          rdy, ce, we, oe, drv, rv;
        logic [1:0]    kind;   // 0 idle, 1 write phase, 2 write pulse, 3 read
        logic [AW-1:0] addr;
        logic [DW-1:0] wd;
        logic [DW-1:0] rd;
    } exp_t;

    exp_t          expq[$];
    logic [DW-1:0] ref_mem[int unsigned];
    logic [DW-1:0] cells[int unsigned];
    int            checks = 0;
    int            errors = 0;
    bit            model_ready = 1'b0;
    logic [DW-1:0] exp_rdata = '0;
    int            rd_cyc = 0;
    logic          we_prev = 1'b1;

    function automatic logic [DW-1:0] blank(input logic [AW-1:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction

    function automatic logic [DW-1:0] cell_rd(input logic [AW-1:0] a);
        return cells.exists(a) ? cells[a] : blank(a);
    endfunction

    function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
        return ref_mem.exists(a) ? ref_mem[a] : blank(a);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    // Reference model: queue the expected cycles when a request is taken.
    always @(posedge clk) begin
        if (rst_n && model_ready && req_valid) begin
            exp_t e;
            e = '0;
            e.addr = req_addr;
            e.wd   = req_wdata;
            if (req_write) begin
                e.kind = 2'd1; e.ce = 1'b0; e.we = 1'b1; e.oe = 1'b1; e.drv = 1'b0;
                expq.push_back(e);
                for (int i = 0; i < WP; i++) begin
                    e.kind = 2'd2; e.ce = 1'b0; e.we = 1'b0; e.oe = 1'b1; e.drv = 1'b1;
                    expq.push_back(e);
                end
                for (int i = 0; i < DH; i++) begin
                    e.kind = 2'd1; e.ce = 1'b1; e.we = 1'b1; e.oe = 1'b1; e.drv = 1'b1;
                    expq.push_back(e);
                end
                ref_mem[req_addr] = req_wdata;
            end else begin
                for (int i = 0; i < AA; i++) begin
                    e.kind = 2'd3; e.ce = 1'b0; e.we = 1'b1; e.oe = 1'b0; e.drv = 1'b0;
                    expq.push_back(e);
                end
                e.kind = 2'd3; e.ce = 1'b1; e.we = 1'b1; e.oe = 1'b1; e.drv = 1'b0;
                e.rv = 1'b1; e.rd = ref_rd(req_addr);
                expq.push_back(e);
            end
            model_ready = 1'b0;
        end
    end

    // Mid-cycle comparison and memory model.
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t  e;
            string tg;
            if (expq.size() > 0) begin
                e = expq.pop_front();
                model_ready = 1'b0;
            end else begin
                e = '0;
                e.rdy = 1'b1; e.ce = 1'b1; e.we = 1'b1; e.oe = 1'b1;
                model_ready = 1'b1;
            end
            case (e.kind)
                2'd0: tg = "R1";
                2'd1: tg = "R3";
                2'd2: tg = "R10";
                default: tg = "R5";
            endcase
            if (e.rv) exp_rdata = e.rd;
            chk("R7", "ready", 32'(req_ready), 32'(e.rdy));
            chk(tg, "ce_n", 32'(mem_ce_n), 32'(e.ce));
            chk(tg, "we_n", 32'(mem_we_n), 32'(e.we));
            chk("R4", "oe_n", 32'(mem_oe_n), 32'(e.oe));
            chk("R8", "dq_oe", 32'(mem_dq_oe), 32'(e.drv));
            chk("R6", "rsp_valid", 32'(rsp_valid), 32'(e.rv));
            chk("R6", "rsp_rdata", 32'(rsp_rdata), 32'(exp_rdata));
            if (!e.ce) chk("R9", "mem_addr", 32'(mem_addr), 32'(e.addr));
            if (e.drv) chk("R2", "dq_out", 32'(mem_dq_out), 32'(e.wd));
            // Memory stores on the rising edge of the write strobe.
            if (!we_prev && mem_we_n && mem_dq_oe) cells[mem_addr] = mem_dq_out;
            we_prev = mem_we_n;
            // Data is valid only from the last access cycle; before that it is inverted.
            if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
                mem_dq_in = (rd_cyc >= AA - 1) ? cell_rd(mem_addr) : ~cell_rd(mem_addr);
                rd_cyc++;
            end else begin
                mem_dq_in = 8'h00;
                rd_cyc = 0;
            end
        end
    end

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = ~wr; req_addr = ~a; req_wdata = ~d;  // R2
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);                 // R1 idle after reset
        issue(1'b1, 19'h12345, 8'h5A);             // R3
        issue(1'b0, 19'h12345, 8'h00);             // R5 R6
        issue(1'b1, 19'h00000, 8'hC3);
        issue(1'b1, 19'h7FFFF, 8'h81);
        issue(1'b0, 19'h7FFFF, 8'h00);
        issue(1'b0, 19'h00000, 8'h00);
        issue(1'b0, 19'h2AAAA, 8'h00);             // never written
        issue(1'b0, 19'h2AAAA, 8'h00);             // read after read
        issue(1'b1, 19'h00000, 8'h3F);             // overwrite
        repeat (4) @(negedge clk);
        issue(1'b0, 19'h00000, 8'h00);
        for (int i = 0; i < 8; i++) issue(1'b1, 19'(i * 4099), 8'(i * 37 + 1));
        for (int i = 7; i >= 0; i--) issue(1'b0, 19'(i * 4099), 8'h00);
        repeat (8) @(negedge clk);
        chk("R1", "queue drained", 32'(expq.size()), 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule